// File: doc/BRIEF.md
# Flash Segment Write-Protect Controller

This block sits between a processor bus and a word-addressed flash array and decides whether a programming write may go ahead. The array is divided into eight equal segments. Each segment has its own enable bit in a control register, and a programming operation aimed at a segment whose bit is clear is refused. Erase is never segmented: an erase command always acts on the whole array, whatever the enable bits hold.

The block keeps a 16-bit write-address register that names the word to be programmed. It fills this register in one of two ways, chosen by a mode bit:

- In array-access mode, a bus write into the array window captures the bus address and starts programming in the same operation.
- In register-access mode, software loads the address register directly and then writes a data register to start programming.

An accepted operation produces a one-cycle program strobe carrying the address and data. A refused one produces a one-cycle blocked pulse instead. A 5-bit manufacturing test register exists but cannot be reached from the bus.

Top module: `flash_seg_guard`

## Requirements
- R1: After reset, every segment enable is 0, the mode is register-access, and the write-address and data registers read 0.
- R2: Register space (`bus_reg_sel`=1) is decoded from `bus_addr[1:0]`:
  - Offset 0 is the control register. Bits 15:8 are the segment enables, with bit 8+n enabling segment n. Bit 0 is the mode (1 = array-access). Writing 1 to bit 1 issues an erase. A read returns the enables in bits 15:8, the mode in bit 0, and zeros elsewhere.
- R3: In register-access mode, a write to offset 1 loads the write-address register, and a read of offset 1 returns it. Array-window writes are ignored.
- R4: In register-access mode, a write to offset 3 starts programming its data at the address held in the write-address register.
- R5: In array-access mode, an array write whose address is inside the array loads that address into the write-address register and starts programming. Writes to offsets 1 and 3 are ignored.
- R6: The segment of an address is (address − ARRAY_BASE) / SEG_WORDS. If that segment is enabled, `prog_go` is high for one cycle in the cycle after the write. In that cycle `prog_addr` holds the address and `prog_data` holds the data. The data is also kept and can be read at offset 3.
- R7: If the segment is disabled, `prog_blocked` pulses in that same cycle instead of `prog_go`, and the stored data is left unchanged.
- R8: An address outside ARRAY_BASE to ARRAY_BASE + 8·SEG_WORDS − 1 raises neither pulse. In array-access mode such a write leaves the write-address register unchanged.
- R9: A control write with bit 1 set pulses `erase_go` in the next cycle, whatever the enables and mode. Bit 1 is not stored.
- R10: Offset 2, the test register, is not bus-accessible. Writes to it change nothing, and reads of it return 0.
- R11: `prog_go` and `prog_blocked` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Bus write strobe for one cycle |
| bus_reg_sel | input | 1 | 1 selects register space, 0 selects the array window |
| bus_addr | input | 16 | Word address, or register offset in bits 1:0 |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Register read data (combinational, 0 outside register space) |
| prog_go | output | 1 | Accepted program strobe |
| prog_blocked | output | 1 | Write refused by segment protection |
| prog_addr | output | 16 | Write-address register |
| prog_data | output | 16 | Data of the last accepted program operation |
| erase_go | output | 1 | Whole-array erase strobe |

## Verification
The hardest case to reach is a register-access programming command whose latched address is outside the array. The address register must be loaded out of range first, and then the data register written. This can only happen in register-access mode, because in array-access mode an out-of-range address never reaches the register.

The vector table builds that sequence explicitly. It also walks both mode switches and the segment boundary words 0x07FF, 0x0800, 0x3FFF and 0x4000, and it reads back the stored data after a blocked write. The run ends with a reset in the middle of activity.

// File: rtl/flash_seg_pkg.sv
package flash_seg_pkg;
    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 16;
    localparam int NUM_SEG = 8;
    localparam int SEG_W   = $clog2(NUM_SEG);

    // control register field positions
    localparam int CTRL_MODE_BIT  = 0;
    localparam int CTRL_ERASE_BIT = 1;
    localparam int CTRL_SEG_LSB   = 8;

    typedef enum logic [1:0] {
        OFS_CTRL  = 2'd0,
        OFS_WADR  = 2'd1,
        OFS_TEST  = 2'd2,
        OFS_PDATA = 2'd3
    } reg_ofs_e;

    typedef struct packed {
        logic [NUM_SEG-1:0] seg_en;
        logic               arr_mode;
        logic [ADDR_W-1:0]  wadr;
        logic [DATA_W-1:0]  pdata;
        logic               go;
        logic               blk;
        logic               era;
    } guard_state_t;
endpackage

// File: rtl/flash_seg_decode.sv
module flash_seg_decode
    import flash_seg_pkg::*;
#(
    parameter logic [ADDR_W-1:0] ARRAY_BASE = '0,
    parameter int                SEG_WORDS  = 2048
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_range,
    output logic [SEG_W-1:0]  seg_idx
);
    localparam int OFF_W  = $clog2(SEG_WORDS);
    localparam int SPAN_W = OFF_W + SEG_W;

    logic [ADDR_W:0] diff;

    always_comb begin
        diff     = {1'b0, addr} - {1'b0, ARRAY_BASE};
        in_range = !diff[ADDR_W] && (diff[ADDR_W-1:SPAN_W] == '0);
        seg_idx  = diff[OFF_W +: SEG_W];
    end
endmodule

// File: rtl/flash_seg_gate.sv
module flash_seg_gate
    import flash_seg_pkg::*;
(
    input  logic [NUM_SEG-1:0] seg_en,
    input  logic [SEG_W-1:0]   seg_idx,
    output logic               hit
);
    logic [NUM_SEG-1:0] sel_and_en;

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
        assign sel_and_en[g] = seg_en[g] && (seg_idx == SEG_W'(g));
    end

    assign hit = |sel_and_en;
endmodule

// File: rtl/flash_seg_guard.sv
module flash_seg_guard
    import flash_seg_pkg::*;
#(
    parameter logic [ADDR_W-1:0] ARRAY_BASE = '0,
    parameter int                SEG_WORDS  = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic              bus_reg_sel,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              prog_go,
    output logic              prog_blocked,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic              erase_go
);
    guard_state_t      r_q, r_d;
    reg_ofs_e          ofs;
    logic [ADDR_W-1:0] chk_addr;
    logic              in_range;
    logic [SEG_W-1:0]  seg_idx;
    logic              seg_hit;
    logic              reg_wr;
    logic              arr_wr;
    logic              prog_try;

    assign ofs      = reg_ofs_e'(bus_addr[1:0]);
    // array mode checks the bus address, register mode the latched one
    assign chk_addr = r_q.arr_mode ? bus_addr : r_q.wadr;

    flash_seg_decode #(
        .ARRAY_BASE (ARRAY_BASE),
        .SEG_WORDS  (SEG_WORDS)
    ) u_decode (
        .addr     (chk_addr),
        .in_range (in_range),
        .seg_idx  (seg_idx)
    );

    flash_seg_gate u_gate (
        .seg_en  (r_q.seg_en),
        .seg_idx (seg_idx),
        .hit     (seg_hit)
    );

    always_comb begin
        r_d      = r_q;
        r_d.go   = 1'b0;
        r_d.blk  = 1'b0;
        r_d.era  = 1'b0;
        reg_wr   = bus_we && bus_reg_sel;
        arr_wr   = bus_we && !bus_reg_sel;
        prog_try = 1'b0;

        if (reg_wr) begin
            case (ofs)
                OFS_CTRL: begin
                    r_d.seg_en   = bus_wdata[CTRL_SEG_LSB +: NUM_SEG];
                    r_d.arr_mode = bus_wdata[CTRL_MODE_BIT];
                    r_d.era      = bus_wdata[CTRL_ERASE_BIT];
                end
                OFS_WADR:  if (!r_q.arr_mode) r_d.wadr = bus_wdata;
                OFS_PDATA: if (!r_q.arr_mode) prog_try = 1'b1;
                default: ;
            endcase
        end

        if (arr_wr && r_q.arr_mode && in_range) begin
            r_d.wadr = bus_addr;
            prog_try = 1'b1;
        end

        if (prog_try && in_range) begin
            if (seg_hit) begin
                r_d.go    = 1'b1;
                r_d.pdata = bus_wdata;
            end else begin
                r_d.blk = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_reg_sel) begin
            case (ofs)
                OFS_CTRL: begin
                    bus_rdata[CTRL_SEG_LSB +: NUM_SEG] = r_q.seg_en;
                    bus_rdata[CTRL_MODE_BIT]           = r_q.arr_mode;
                end
                OFS_WADR:  bus_rdata = r_q.wadr;
                OFS_PDATA: bus_rdata = r_q.pdata;
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign prog_go      = r_q.go;
    assign prog_blocked = r_q.blk;
    assign prog_addr    = r_q.wadr;
    assign prog_data    = r_q.pdata;
    assign erase_go     = r_q.era;
endmodule

// File: rtl/flash_seg_guard_chk.sv
module flash_seg_guard_chk
    import flash_seg_pkg::*;
#(
    parameter logic [ADDR_W-1:0] ARRAY_BASE = '0,
    parameter int                SEG_WORDS  = 2048
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_we,
    input logic               bus_reg_sel,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic               prog_go,
    input logic               prog_blocked,
    input logic [ADDR_W-1:0]  prog_addr,
    input logic               erase_go,
    input logic [NUM_SEG-1:0] seg_en,
    input logic               arr_mode
);
    localparam int unsigned LO = int'(ARRAY_BASE);
    localparam int unsigned HI = LO + NUM_SEG * SEG_WORDS;

    function automatic logic inside_arr(input logic [ADDR_W-1:0] a);
        return (int'(a) >= LO) && (int'(a) < HI);
    endfunction

    function automatic int seg_of(input logic [ADDR_W-1:0] a);
        return (int'(a) - int'(LO)) / SEG_WORDS;
    endfunction

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (seg_en == '0 && !arr_mode && prog_addr == '0));

    // R11
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(prog_go && prog_blocked));

    // R6
    go_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_go |-> (inside_arr(prog_addr) && seg_en[seg_of(prog_addr)]));

    // R7
    blk_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_blocked |-> (inside_arr(prog_addr) && !seg_en[seg_of(prog_addr)]));

    // R8
    out_of_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !bus_reg_sel && arr_mode && !inside_arr(bus_addr))
        |=> (!prog_go && !prog_blocked && $stable(prog_addr)));

    // R9
    erase_always_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_reg_sel && bus_addr[1:0] == 2'd0 && bus_wdata[CTRL_ERASE_BIT])
        |=> erase_go);

    // R10
    test_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_reg_sel && bus_addr[1:0] == 2'd2) |-> (bus_rdata == '0));
endmodule

bind flash_seg_guard flash_seg_guard_chk #(
    .ARRAY_BASE (ARRAY_BASE),
    .SEG_WORDS  (SEG_WORDS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_we       (bus_we),
    .bus_reg_sel  (bus_reg_sel),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .prog_go      (prog_go),
    .prog_blocked (prog_blocked),
    .prog_addr    (prog_addr),
    .erase_go     (erase_go),
    .seg_en       (r_q.seg_en),
    .arr_mode     (r_q.arr_mode)
);

// File: tb/flash_seg_guard_bench.sv
module flash_seg_guard_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 31;

    typedef struct packed {
        logic        rd;
        logic        sel;
        logic [15:0] addr;
        logic [15:0] data;
        logic        go;
        logic        blk;
        logic        era;
        logic [15:0] val;   // prog_addr after a write, rdata for a read
        logic [3:0]  req;
    } vec_t;

    // rd, sel, addr, data, go, blk, era, val, req
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 1'b1, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 4'd1},  // R1 ctrl
        '{1'b1, 1'b1, 16'h0001, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 4'd1},  // R1 wadr
        '{1'b0, 1'b1, 16'h0001, 16'h0123, 1'b0, 1'b0, 1'b0, 16'h0123, 4'd3},  // R3
        '{1'b0, 1'b1, 16'h0003, 16'hBEEF, 1'b0, 1'b1, 1'b0, 16'h0123, 4'd7},  // R7
        '{1'b1, 1'b1, 16'h0003, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 4'd7},  // R7
        '{1'b0, 1'b1, 16'h0000, 16'h0500, 1'b0, 1'b0, 1'b0, 16'h0123, 4'd2},  // R2
        '{1'b0, 1'b1, 16'h0003, 16'h1111, 1'b1, 1'b0, 1'b0, 16'h0123, 4'd4},  // R4
        '{1'b1, 1'b1, 16'h0003, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h1111, 4'd6},  // R6
        '{1'b0, 1'b1, 16'h0001, 16'h0900, 1'b0, 1'b0, 1'b0, 16'h0900, 4'd3},  // R3
        '{1'b0, 1'b1, 16'h0003, 16'h2222, 1'b0, 1'b1, 1'b0, 16'h0900, 4'd7},  // R7
        '{1'b0, 1'b1, 16'h0001, 16'h1000, 1'b0, 1'b0, 1'b0, 16'h1000, 4'd3},  // R3
        '{1'b0, 1'b1, 16'h0003, 16'h3333, 1'b1, 1'b0, 1'b0, 16'h1000, 4'd6},  // R6
        '{1'b0, 1'b0, 16'h2000, 16'h4444, 1'b0, 1'b0, 1'b0, 16'h1000, 4'd3},  // R3
        '{1'b0, 1'b1, 16'h0001, 16'h5000, 1'b0, 1'b0, 1'b0, 16'h5000, 4'd3},  // R3
        '{1'b0, 1'b1, 16'h0003, 16'h5555, 1'b0, 1'b0, 1'b0, 16'h5000, 4'd8},  // R8
        '{1'b0, 1'b1, 16'h0000, 16'h8101, 1'b0, 1'b0, 1'b0, 16'h5000, 4'd2},  // R2
        '{1'b1, 1'b1, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h8101, 4'd2},  // R2
        '{1'b0, 1'b0, 16'h3FFF, 16'hA5A5, 1'b1, 1'b0, 1'b0, 16'h3FFF, 4'd5},  // R5
        '{1'b0, 1'b0, 16'h07FF, 16'h0F0F, 1'b1, 1'b0, 1'b0, 16'h07FF, 4'd6},  // R6
        '{1'b0, 1'b0, 16'h0800, 16'h5A5A, 1'b0, 1'b1, 1'b0, 16'h0800, 4'd7},  // R7
        '{1'b1, 1'b1, 16'h0003, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0F0F, 4'd7},  // R7
        '{1'b0, 1'b0, 16'h4000, 16'h6666, 1'b0, 1'b0, 1'b0, 16'h0800, 4'd8},  // R8
        '{1'b0, 1'b1, 16'h0001, 16'h1234, 1'b0, 1'b0, 1'b0, 16'h0800, 4'd5},  // R5
        '{1'b0, 1'b1, 16'h0003, 16'h9999, 1'b0, 1'b0, 1'b0, 16'h0800, 4'd5},  // R5
        '{1'b0, 1'b1, 16'h0002, 16'hFFFF, 1'b0, 1'b0, 1'b0, 16'h0800, 4'd10}, // R10
        '{1'b1, 1'b1, 16'h0002, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 4'd10}, // R10
        '{1'b1, 1'b1, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h8101, 4'd10}, // R10
        '{1'b0, 1'b1, 16'h0000, 16'h0003, 1'b0, 1'b0, 1'b1, 16'h0800, 4'd9},  // R9
        '{1'b1, 1'b1, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0001, 4'd2},  // R2
        '{1'b0, 1'b1, 16'h0000, 16'h0002, 1'b0, 1'b0, 1'b1, 16'h0800, 4'd9},  // R9
        '{1'b1, 1'b1, 16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0, 16'h0000, 4'd2}   // R2
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic        bus_reg_sel = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        prog_go;
    logic        prog_blocked;
    logic [15:0] prog_addr;
    logic [15:0] prog_data;
    logic        erase_go;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    flash_seg_guard u_flash_seg_guard (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_we       (bus_we),
        .bus_reg_sel  (bus_reg_sel),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .prog_go      (prog_go),
        .prog_blocked (prog_blocked),
        .prog_addr    (prog_addr),
        .prog_data    (prog_data),
        .erase_go     (erase_go)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle_bus();
        bus_we      = 1'b0;
        bus_reg_sel = 1'b0;
        bus_addr    = '0;
        bus_wdata   = '0;
    endtask

    // drive at a falling edge, sample pulses one falling edge later
    task automatic bus_write(input logic sel, input logic [15:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_reg_sel = sel; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        idle_bus();
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_we = 1'b0; bus_reg_sel = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        idle_bus();
    endtask

    initial begin
        logic [15:0] rd;
        repeat (3) @(negedge clk);
        // R1: outputs quiet in reset
        chk("R1 prog_go in reset", {15'd0, prog_go}, 16'h0000);
        chk("R1 prog_addr in reset", prog_addr, 16'h0000);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            string tag;
            tag = $sformatf("R%0d vec %0d", VECS[i].req, i);
            if (VECS[i].rd) begin
                bus_read(VECS[i].addr, rd);
                chk({tag, " rdata"}, rd, VECS[i].val);
            end else begin
                bus_write(VECS[i].sel, VECS[i].addr, VECS[i].data);
                chk({tag, " prog_addr"}, prog_addr, VECS[i].val);
            end
            chk({tag, " go/blk/erase"}, {13'd0, prog_go, prog_blocked, erase_go},
                {13'd0, VECS[i].go, VECS[i].blk, VECS[i].era});
        end

        // R6: strobe carries address and data together
        bus_write(1'b1, 16'h0000, 16'hFF01);
        bus_write(1'b0, 16'h1ABC, 16'h7777);
        chk("R6 prog_go", {15'd0, prog_go}, 16'h0001);
        chk("R6 prog_addr", prog_addr, 16'h1ABC);
        chk("R6 prog_data", prog_data, 16'h7777);
        @(negedge clk);
        chk("R11 prog_go single cycle", {15'd0, prog_go}, 16'h0000);

        // R1: reset in mid-run clears state
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        bus_read(16'h0000, rd);
        chk("R1 ctrl after reset", rd, 16'h0000);
        bus_read(16'h0001, rd);
        chk("R1 wadr after reset", rd, 16'h0000);
        bus_read(16'h0003, rd);
        chk("R1 pdata after reset", rd, 16'h0000);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule